// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides what the core does when the CPU executes its idle instruction. Two armed bits in a control register, a power-down bit and a deep-mode bit, select one of three low-power states: IDLE (only the CPU clock stops), STANDBY (CPU and most peripherals stop; the oscillator and timer 1 keep running) or HALT (the oscillator and every internal clock stop). From these states the block drives gating enables for the CPU clock, the peripheral clocks, the oscillator, the timer 1 clock and the watchdog clock.

While in a low-power state the block watches the external interrupt lines and the timer 1 interrupt, each qualified by its enable flag. When a qualifying event arrives it walks the core back to RUN through a short wake state. In that state the oscillator is enabled again before the CPU clock. Two straps change the behaviour. A low-power disable strap turns every idle instruction into IDLE and freezes the mode bits. A hard-watchdog strap makes one external interrupt lane non-maskable for as long as the core is out of RUN. A lock bit in the same register makes the mode bits read-only until the next reset.

Top module: `lpm_seq`

## Requirements
- R1: During and after reset the mode output reads RUN (encoding 0), all five enables are 1, nmi_force is 0, and both mode bits and the lock bit are 0.
- R2: An idle strobe in RUN with the power-down bit (cfg_wdata bit 0) at 0 moves the mode one cycle later to IDLE (encoding 1), whatever the deep-mode bit (bit 1) holds. In IDLE only cpu_clk_en is 0.
- R3: An idle strobe in RUN with power-down at 1 and deep-mode at 0 moves the mode to STANDBY (encoding 2). In STANDBY cpu_clk_en, periph_clk_en and wdog_clk_en are 0, and osc_en and t1_clk_en are 1.
- R4: An idle strobe in RUN with both bits at 1 moves the mode to HALT (encoding 3), where all five enables are 0.
- R5: IDLE and STANDBY are left on any external interrupt whose enable is 1, or on the timer 1 interrupt with its enable at 1. HALT is left only on an enabled external interrupt, and the timer 1 interrupt has no effect there. A line whose enable is 0 has no effect in any state.
- R6: The cycle after a qualifying wake event, the mode reads WAKE (encoding 4), with osc_en, periph_clk_en and t1_clk_en at 1 and cpu_clk_en and wdog_clk_en at 0. The cycle after that the mode reads RUN with all enables at 1.
- R7: While lp_off_strap is 1, configuration writes leave both mode bits unchanged, and every idle strobe enters IDLE.
- R8: While hwd_strap is 1, external lane 0 wakes every low-power state whether or not its enable is set, and nmi_force is 1 in every mode other than RUN.
- R9: A write with bit 7 set sets a lock bit that stays set until reset. The write that sets it still updates the mode bits, and every later write leaves them unchanged.
- R10: An idle strobe outside RUN has no effect, and a low-power state is entered only from RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| idle_exec | input | 1 | One-cycle strobe: the CPU executed its idle instruction |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | REG_W | Write data: bit 0 power-down, bit 1 deep-mode, bit 7 lock |
| lp_off_strap | input | 1 | Strap: low-power modes disabled, IDLE only |
| hwd_strap | input | 1 | Strap: hard watchdog, lane 0 non-maskable when out of RUN |
| ext_irq | input | N_EXT | External interrupt request lines |
| ext_irq_en | input | N_EXT | Enable flag per external line |
| t1_irq | input | 1 | Timer 1 interrupt request |
| t1_irq_en | input | 1 | Timer 1 interrupt enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| t1_clk_en | output | 1 | Timer 1 clock enable |
| wdog_clk_en | output | 1 | Watchdog clock enable |
| lp_mode | output | 3 | Current mode: 0 RUN, 1 IDLE, 2 STANDBY, 3 HALT, 4 WAKE |
| nmi_force | output | 1 | Lane 0 is being treated as non-maskable |

## Verification
On every cycle the assertions check the wake walk: WAKE always gives way to RUN, and the CPU clock never rises unless the oscillator was already on. They also check that low-power states are reached only from RUN, that HALT holds when no enabled external line is raised, and that the strapped lane and the low-power strap take effect. Only the bench's scenarios can show the mapping from armed bits to the selected state and the full enable set of each state. The same holds for the masking of each wake source under each enable and strap setting, and for the writes that are ignored under the lock and the strap. Those effects appear only in what a later idle strobe selects.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      LPM_RUN  = 3'd0,
      LPM_IDLE = 3'd1,
      LPM_STBY = 3'd2,
      LPM_HALT = 3'd3,
      LPM_WAKE = 3'd4
   } lpm_state_e;

   typedef struct packed {
      logic cpu;
      logic periph;
      logic osc;
      logic tmr1;
      logic wdog;
   } lpm_gate_t;

   function automatic lpm_gate_t lpm_gates(input lpm_state_e st);
      lpm_gate_t g;
      case (st)
         LPM_RUN:  g = '{cpu: 1'b1, periph: 1'b1, osc: 1'b1, tmr1: 1'b1, wdog: 1'b1};
         LPM_IDLE: g = '{cpu: 1'b0, periph: 1'b1, osc: 1'b1, tmr1: 1'b1, wdog: 1'b1};
         LPM_STBY: g = '{cpu: 1'b0, periph: 1'b0, osc: 1'b1, tmr1: 1'b1, wdog: 1'b0};
         LPM_HALT: g = '{cpu: 1'b0, periph: 1'b0, osc: 1'b0, tmr1: 1'b0, wdog: 1'b0};
         LPM_WAKE: g = '{cpu: 1'b0, periph: 1'b1, osc: 1'b1, tmr1: 1'b1, wdog: 1'b0};
         default:  g = '{cpu: 1'b1, periph: 1'b1, osc: 1'b1, tmr1: 1'b1, wdog: 1'b1};
      endcase
      return g;
   endfunction

   function automatic logic lpm_is_low(input lpm_state_e st);
      return (st == LPM_IDLE) || (st == LPM_STBY) || (st == LPM_HALT);
   endfunction

endpackage

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg #(
   parameter int REG_W    = 8,
   parameter int PD_POS   = 0,
   parameter int HS_POS   = 1,
   parameter int LOCK_POS = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   input  logic             lp_off,
   output logic             pd,
   output logic             hs,
   output logic             locked
);

   if (PD_POS >= REG_W || HS_POS >= REG_W || LOCK_POS >= REG_W) begin : g_bad_pos
      $error("lpm_cfg_reg: field position outside register width");
   end
   if (PD_POS == HS_POS || PD_POS == LOCK_POS || HS_POS == LOCK_POS) begin : g_overlap
      $error("lpm_cfg_reg: field positions overlap");
   end

   logic pd_q, hs_q, lock_q;
   logic mode_wr;
   logic unused_wdata;

   assign mode_wr      = we && !lock_q && !lp_off;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pd_q   <= 1'b0;
         hs_q   <= 1'b0;
         lock_q <= 1'b0;
      end else begin
         if (mode_wr) begin
            pd_q <= wdata[PD_POS];
            hs_q <= wdata[HS_POS];
         end
         if (we && wdata[LOCK_POS]) begin
            lock_q <= 1'b1;
         end
      end
   end

   assign pd     = pd_q;
   assign hs     = hs_q;
   assign locked = lock_q;

endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
   parameter int N_EXT    = 3,
   parameter int NMI_LANE = 0
) (
   input  logic [N_EXT-1:0] ext_irq,
   input  logic [N_EXT-1:0] ext_en,
   input  logic             t1_irq,
   input  logic             t1_en,
   input  logic             hwd,
   output logic             wake_soft,
   output logic             wake_deep
);

   if (N_EXT < 1) begin : g_bad_n
      $error("lpm_wake_qual: at least one external lane required");
   end
   if (NMI_LANE >= N_EXT) begin : g_bad_lane
      $error("lpm_wake_qual: non-maskable lane outside lane count");
   end

   logic [N_EXT-1:0] lane_ok;

   for (genvar i = 0; i < N_EXT; i++) begin : g_lane
      if (i == NMI_LANE) begin : g_nmi
         assign lane_ok[i] = ext_irq[i] && (ext_en[i] || hwd);
      end else begin : g_plain
         assign lane_ok[i] = ext_irq[i] && ext_en[i];
      end
   end

   assign wake_deep = |lane_ok;
   assign wake_soft = wake_deep || (t1_irq && t1_en);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
   import lpm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idle_exec,
   input  logic       pd,
   input  logic       hs,
   input  logic       lp_off,
   input  logic       wake_soft,
   input  logic       wake_deep,
   output lpm_state_e state
);

   lpm_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         LPM_RUN: begin
            if (idle_exec) begin
               if (lp_off || !pd) state_d = LPM_IDLE;
               else if (hs)       state_d = LPM_HALT;
               else               state_d = LPM_STBY;
            end
         end
         LPM_IDLE, LPM_STBY: begin
            if (wake_soft) state_d = LPM_WAKE;
         end
         LPM_HALT: begin
            if (wake_deep) state_d = LPM_WAKE;
         end
         LPM_WAKE: state_d = LPM_RUN;
         default:  state_d = LPM_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= LPM_RUN;
      else        state_q <= state_d;
   end

   assign state = state_q;

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
   import lpm_pkg::*;
#(
   parameter int REG_W    = 8,
   parameter int N_EXT    = 3,
   parameter int NMI_LANE = 0,
   parameter int PD_POS   = 0,
   parameter int HS_POS   = 1,
   parameter int LOCK_POS = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle_exec,
   input  logic              cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic              lp_off_strap,
   input  logic              hwd_strap,
   input  logic [N_EXT-1:0]  ext_irq,
   input  logic [N_EXT-1:0]  ext_irq_en,
   input  logic              t1_irq,
   input  logic              t1_irq_en,
   output logic              cpu_clk_en,
   output logic              periph_clk_en,
   output logic              osc_en,
   output logic              t1_clk_en,
   output logic              wdog_clk_en,
   output logic [MODE_W-1:0] lp_mode,
   output logic              nmi_force
);

   logic       pd, hs, locked;
   logic       wake_soft, wake_deep;
   lpm_state_e state;
   lpm_gate_t  gates;
   logic       unused_lock;

   lpm_cfg_reg #(
      .REG_W    (REG_W),
      .PD_POS   (PD_POS),
      .HS_POS   (HS_POS),
      .LOCK_POS (LOCK_POS)
   ) i_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .wdata  (cfg_wdata),
      .lp_off (lp_off_strap),
      .pd     (pd),
      .hs     (hs),
      .locked (locked)
   );

   lpm_wake_qual #(
      .N_EXT    (N_EXT),
      .NMI_LANE (NMI_LANE)
   ) i_wake (
      .ext_irq   (ext_irq),
      .ext_en    (ext_irq_en),
      .t1_irq    (t1_irq),
      .t1_en     (t1_irq_en),
      .hwd       (hwd_strap),
      .wake_soft (wake_soft),
      .wake_deep (wake_deep)
   );

   lpm_fsm i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle_exec (idle_exec),
      .pd        (pd),
      .hs        (hs),
      .lp_off    (lp_off_strap),
      .wake_soft (wake_soft),
      .wake_deep (wake_deep),
      .state     (state)
   );

   assign unused_lock   = locked;
   assign gates         = lpm_gates(state);
   assign cpu_clk_en    = gates.cpu;
   assign periph_clk_en = gates.periph;
   assign osc_en        = gates.osc;
   assign t1_clk_en     = gates.tmr1;
   assign wdog_clk_en   = gates.wdog;
   assign lp_mode       = state;
   assign nmi_force     = hwd_strap && (state != LPM_RUN);

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk
   import lpm_pkg::*;
#(
   parameter int N_EXT    = 3,
   parameter int NMI_LANE = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              idle_exec,
   input logic              lp_off_strap,
   input logic              hwd_strap,
   input logic [N_EXT-1:0]  ext_irq,
   input logic [N_EXT-1:0]  ext_irq_en,
   input logic              cpu_clk_en,
   input logic              osc_en,
   input logic [MODE_W-1:0] lp_mode
);

   logic in_low;
   assign in_low = (lp_mode == LPM_IDLE) || (lp_mode == LPM_STBY) || (lp_mode == LPM_HALT);

   AST_WAKE_THEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_mode == LPM_WAKE) |=> (lp_mode == LPM_RUN)); // R6

   AST_OSC_BEFORE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_clk_en) |-> $past(osc_en)); // R6

   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ((lp_mode == LPM_HALT) && !(|(ext_irq & ext_irq_en))
       && !(hwd_strap && ext_irq[NMI_LANE])) |=> (lp_mode == LPM_HALT)); // R5

   AST_STRAP_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_off_strap && (lp_mode == LPM_RUN) && idle_exec) |=> (lp_mode == LPM_IDLE)); // R7

   AST_NMI_LANE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (hwd_strap && ext_irq[NMI_LANE] && in_low) |=> (lp_mode == LPM_WAKE)); // R8

   AST_ENTRY_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_low && !$stable(lp_mode)) |-> ($past(lp_mode) == LPM_RUN)); // R10

endmodule

bind lpm_seq lpm_seq_chk #(
   .N_EXT    (N_EXT),
   .NMI_LANE (NMI_LANE)
) i_lpm_seq_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .idle_exec    (idle_exec),
   .lp_off_strap (lp_off_strap),
   .hwd_strap    (hwd_strap),
   .ext_irq      (ext_irq),
   .ext_irq_en   (ext_irq_en),
   .cpu_clk_en   (cpu_clk_en),
   .osc_en       (osc_en),
   .lp_mode      (lp_mode)
);

// File: tb/test_lpm_seq.sv
`timescale 1ns/1ps
module test_lpm_seq;

   localparam int N_EXT = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             idle_exec = 1'b0;
   logic             cfg_we = 1'b0;
   logic [7:0]       cfg_wdata = '0;
   logic             lp_off_strap = 1'b0;
   logic             hwd_strap = 1'b0;
   logic [N_EXT-1:0] ext_irq = '0;
   logic [N_EXT-1:0] ext_irq_en = '0;
   logic             t1_irq = 1'b0;
   logic             t1_irq_en = 1'b0;
   logic             cpu_clk_en, periph_clk_en, osc_en, t1_clk_en, wdog_clk_en;
   logic [2:0]       lp_mode;
   logic             nmi_force;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   lpm_seq i_lpm_seq (
      .clk(clk), .rst_n(rst_n), .idle_exec(idle_exec), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .lp_off_strap(lp_off_strap), .hwd_strap(hwd_strap),
      .ext_irq(ext_irq), .ext_irq_en(ext_irq_en), .t1_irq(t1_irq), .t1_irq_en(t1_irq_en),
      .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
      .t1_clk_en(t1_clk_en), .wdog_clk_en(wdog_clk_en), .lp_mode(lp_mode),
      .nmi_force(nmi_force)
   );

   // expected enables {cpu,periph,osc,t1,wdog} per mode encoding
   function automatic logic [4:0] exp_gates(input int m);
      case (m)
         0: return 5'b11111;
         1: return 5'b01111;
         2: return 5'b00110;
         3: return 5'b00000;
         default: return 5'b01110;
      endcase
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_mode(input string req, input int m);
      chk(req, "mode", int'(lp_mode), m);
      chk(req, "gates", int'({cpu_clk_en, periph_clk_en, osc_en, t1_clk_en, wdog_clk_en}),
          int'(exp_gates(m)));
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; idle_exec = 0; cfg_we = 0; ext_irq = '0; ext_irq_en = '0;
      t1_irq = 0; t1_irq_en = 0;
      tick(); tick();
      chk_mode("R1", 0);
      rst_n = 1'b1;
      tick();
      chk_mode("R1", 0);
      chk("R1", "nmi_force", int'(nmi_force), 0);
   endtask

   task automatic wr(input logic [7:0] d);
      cfg_we = 1; cfg_wdata = d; tick(); cfg_we = 0;
   endtask

   task automatic idle();
      idle_exec = 1; tick(); idle_exec = 0;
   endtask

   // wake through enabled lane 1 and check the two-step return
   task automatic wake_back(input string req);
      ext_irq = 3'b010; ext_irq_en = 3'b010; tick();
      chk_mode(req, 4);
      ext_irq = '0; ext_irq_en = '0; tick();
      chk_mode(req, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL R6 watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // sweep: mode bits x straps x wake source x enable
      for (int lp = 0; lp < 2; lp++)
      for (int hw = 0; hw < 2; hw++)
      for (int pd = 0; pd < 2; pd++)
      for (int hs = 0; hs < 2; hs++)
      for (int src = 0; src < 4; src++)
      for (int en = 0; en < 2; en++) begin
         int  m;
         bit  wk;
         lp_off_strap = lp[0]; hwd_strap = hw[0];
         do_reset();
         wr({6'b0, hs[0], pd[0]});
         idle();
         m = (lp != 0) ? 1 : ((pd != 0) ? ((hs != 0) ? 3 : 2) : 1);
         chk_mode(m == 1 ? ((lp != 0) ? "R7" : "R2") : (m == 2 ? "R3" : "R4"), m);
         chk("R8", "nmi_force low", int'(nmi_force), hw);
         if (src < 3) wk = (en != 0) || (hw != 0 && src == 0);
         else         wk = (en != 0) && (m != 3);
         if (src < 3) begin
            ext_irq = 3'(1 << src); ext_irq_en = en[0] ? 3'(1 << src) : 3'b000;
         end else begin
            t1_irq = 1; t1_irq_en = en[0];
         end
         tick();
         if (wk) begin
            chk_mode((src == 0 && en == 0) ? "R8" : "R6", 4);
            chk("R8", "nmi_force wake", int'(nmi_force), hw);
            ext_irq = '0; ext_irq_en = '0; t1_irq = 0; t1_irq_en = 0;
            tick();
            chk_mode("R6", 0);
            chk("R8", "nmi_force run", int'(nmi_force), 0);
         end else begin
            chk_mode("R5", m);
            ext_irq = '0; ext_irq_en = '0; t1_irq = 0; t1_irq_en = 0;
            idle_exec = 1; cfg_we = 1; cfg_wdata = 8'h03; tick();
            idle_exec = 0; cfg_we = 0;
            chk_mode("R10", m);
            wake_back("R5");
         end
      end

      // R9: lock is sticky, locking write still lands
      lp_off_strap = 0; hwd_strap = 0;
      do_reset();
      wr(8'h81);
      idle();
      chk_mode("R9", 2);
      wake_back("R9");
      wr(8'h03);
      idle();
      chk_mode("R9", 2);
      wake_back("R9");
      wr(8'h00);
      idle();
      chk_mode("R9", 2);
      wake_back("R9");
      do_reset();
      idle();
      chk_mode("R1", 1);
      wake_back("R1");

      // R7: write under strap is dropped, seen after strap is removed
      lp_off_strap = 1;
      do_reset();
      wr(8'h03);
      lp_off_strap = 0;
      idle();
      chk_mode("R7", 1);
      wake_back("R7");

      // R10: idle strobe in WAKE ignored
      wr(8'h03);
      idle();
      chk_mode("R4", 3);
      ext_irq = 3'b100; ext_irq_en = 3'b100; tick();
      chk_mode("R6", 4);
      ext_irq = '0; ext_irq_en = '0; idle_exec = 1; tick(); idle_exec = 0;
      chk_mode("R10", 0);
      tick();
      chk_mode("R10", 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule